// File: doc/BRIEF.md
# Strap-configured asynchronous serial transceiver

This block is a full-duplex asynchronous serial transmitter and receiver whose character format is not programmed through registers but taken from five static control inputs. A level-sensitive latch captures those inputs while a control strobe is high and keeps them while it is low. The latched word sets the character length (5 to 8 bits), whether a parity bit is present, odd or even parity, and one or two stop bits. The transmitter and the receiver each advance on their own clock enable, which pulses at sixteen times the bit rate.

The transmit side has one holding register, loaded on the rising edge of a data strobe, in front of a shift stage. It reports whether the holding register can accept another character and whether the last character has been fully sent. The receive side oversamples the serial input, takes each bit at mid-bit, and moves every finished character into a single holding register. It raises data-available, overrun, framing-error and parity-error flags. A shared read bus with an output-enable qualifier carries either the received character or a status word. An external reset returns both directions to idle but keeps the control latch. A separate active-low input clears only data-available.

Top module: `strap_uart`

## Requirements
- R1: Length code `ctl_len` 00, 01, 10, 11 selects 5, 6, 7, 8 data bits. Data is sent least significant bit first after a 0 start bit. A received character is right-justified on `rd_bus` (bit 0 = first data bit), and unused upper bits read 0.
- R2: With `ctl_no_par`=0, a parity bit follows the last data bit. `ctl_even`=0 makes the count of ones over the data and parity bits odd, and `ctl_even`=1 makes it even. The receiver checks against the same rule and sets `rx_parity_err` on a mismatch.
- R3: With `ctl_no_par`=1, no parity bit is sent or expected, the stop bit directly follows the data, and `rx_parity_err` stays 0.
- R4: The transmitted stop level lasts 16 ticks for `ctl_two_stop`=0, 32 ticks for `ctl_two_stop`=1, and 24 ticks for `ctl_two_stop`=1 with 5-bit characters. From the start bit falling to `tx_done` rising takes 16×(1+data+parity) plus the stop ticks, in clock cycles with the tick always high.
- R5: Every transmitted bit lasts 16 tx ticks. The receiver detects a 1-to-0 transition on `rx_serial`, checks the start bit 8 rx ticks later, and samples each following bit 16 ticks after the previous sample.
- R6: A start bit that is high again at its mid-bit sample is ignored: no character is transferred and `rx_ready` does not change.
- R7: `rx_ready` goes to 1 when a character is transferred to the receive holding register. `dav_clr_n`=0 clears `rx_ready` and leaves the data and the other flags unchanged. If a transfer and `dav_clr_n`=0 fall in the same cycle, the transfer wins.
- R8: On each transfer `rx_overrun` becomes 1 if `rx_ready` was still 1 and `dav_clr_n` was 1, and 0 otherwise. `rx_frame_err` becomes 1 if the first stop bit is sampled as 0.
- R9: A rising edge on `tx_load` captures `tx_data` and sets `tx_empty` to 0. `tx_empty` returns to 1 on the tick where the character moves to the shifter.
- R10: `tx_serial` idles at 1. `tx_done` goes to 0 when a start bit goes out, and goes to 1 when the stop time has elapsed, staying 1 until the next start.
- R11: `ext_rst`=1 sets `tx_serial`, `tx_done` and `tx_empty` to 1 and clears `rx_ready`, all error flags and both holding registers. The control latch is left unchanged.
- R12: The control latch takes the control inputs on every clock edge at which `ctl_strobe`=1 and holds them while `ctl_strobe`=0.
- R13: `rd_data_n`=0 puts the received character on `rd_bus`. `rd_stat_n`=0 puts the status word there instead, and takes priority if both are 0: bit 0 parity error, bit 1 framing error, bit 2 overrun, bit 3 data available, bit 4 transmit empty, bits 7:5 zero. `rd_bus_oe` is 1 when either is 0. With `rd_bus_oe`=0, `rd_bus` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst | input | 1 | Synchronous external reset, active high |
| tx_tick16 | input | 1 | Transmit enable, 16 per bit |
| rx_tick16 | input | 1 | Receive enable, 16 per bit |
| ctl_strobe | input | 1 | Control latch enable, latch follows while 1 |
| ctl_len | input | 2 | Character length code |
| ctl_even | input | 1 | 1 even parity, 0 odd parity |
| ctl_two_stop | input | 1 | 1 selects two stop bits (1.5 with 5-bit characters) |
| ctl_no_par | input | 1 | 1 removes the parity bit |
| tx_data | input | 8 | Character to send |
| tx_load | input | 1 | Data strobe, rising edge loads |
| tx_serial | output | 1 | Serial output |
| tx_empty | output | 1 | Transmit holding register free |
| tx_done | output | 1 | Last character fully sent |
| rx_serial | input | 1 | Serial input |
| dav_clr_n | input | 1 | Clears data available when 0 |
| rx_ready | output | 1 | Data available |
| rx_overrun | output | 1 | Overrun flag |
| rx_frame_err | output | 1 | Framing error flag |
| rx_parity_err | output | 1 | Parity error flag |
| rd_data_n | input | 1 | Read received character when 0 |
| rd_stat_n | input | 1 | Read status word when 0 |
| rd_bus | output | 8 | Read bus |
| rd_bus_oe | output | 1 | Read bus output enable |

## Verification
The two receive functions that can meet in one cycle are the transfer of a finished character into the holding register and the clearing of data-available by `dav_clr_n`. The bench holds `dav_clr_n` low through a whole incoming frame, so the clear is active on the very cycle of the transfer. The result is judged by watching `rx_ready` on every cycle: it must be high for exactly one cycle, with the character readable and `rx_overrun` at 0. The clear must not swallow the transfer, and the flag must not stay set.

// File: rtl/strap_uart_pkg.sv
`timescale 1ns/1ps
package strap_uart_pkg;

  localparam int unsigned MAX_BITS = 8;

  typedef struct packed {
    logic [1:0] len_code;
    logic       even_par;
    logic       two_stop;
    logic       no_par;
  } frame_fmt_t;

  // data bits per character: 5 + code
  function automatic logic [3:0] fmt_width(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // data bits plus optional parity bit
  function automatic logic [3:0] fmt_body_bits(input frame_fmt_t f);
    return fmt_width(f.len_code) + (f.no_par ? 4'd0 : 4'd1);
  endfunction

  function automatic logic fmt_parity(input logic [MAX_BITS-1:0] d, input frame_fmt_t f);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < int'(MAX_BITS); i++)
      if (i < int'(fmt_width(f.len_code))) acc = acc ^ d[i];
    return acc ^ ~f.even_par;
  endfunction

  // stop time in ticks: one, two, or one and a half bits
  function automatic int unsigned fmt_stop_ticks(input frame_fmt_t f, input int unsigned ovs);
    if (!f.two_stop) return ovs;
    if (f.len_code == 2'b00) return ovs + ovs / 2;
    return 2 * ovs;
  endfunction

endpackage

// File: rtl/strap_uart_tx.sv
`timescale 1ns/1ps
module strap_uart_tx
  import strap_uart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  frame_fmt_t          fmt,
  input  logic                load,
  input  logic [MAX_BITS-1:0] din,
  output logic                line,
  output logic                tbmt,
  output logic                eoc
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned SW = $clog2(2 * OVS + 1);
  localparam int unsigned BW = MAX_BITS + 1;
  localparam int unsigned LW = 4;

  logic                load_q;
  logic                load_rise;
  logic [MAX_BITS-1:0] hold_q;
  logic                tbmt_q, eoc_q, line_q, busy_q, stop_q;
  logic [CW-1:0]       tcnt_q;
  logic [SW-1:0]       scnt_q, stop_len;
  logic [BW-1:0]       shr_q, body;
  logic [LW-1:0]       left_q, body_len;
  logic                start_ev, bit_end, stop_end;

  assign load_rise = load & ~load_q;
  assign start_ev  = tick & ~busy_q & ~tbmt_q;
  assign bit_end   = tick & busy_q & ~stop_q & (tcnt_q == CW'(OVS - 1));
  assign stop_len  = SW'(fmt_stop_ticks(fmt, OVS));
  assign stop_end  = tick & busy_q & stop_q & (scnt_q == stop_len - 1'b1);
  assign body_len  = fmt_body_bits(fmt);

  // data bits right-justified, parity appended just above the last one
  always_comb begin
    body = '0;
    for (int i = 0; i < int'(MAX_BITS); i++)
      if (i < int'(fmt_width(fmt.len_code))) body[i] = hold_q[i];
    if (!fmt.no_par) body[fmt_width(fmt.len_code)] = fmt_parity(hold_q, fmt);
  end

  always_ff @(posedge clk) begin
    load_q <= load;
    if (rst) begin
      hold_q <= '0;
      tbmt_q <= 1'b1;
      eoc_q  <= 1'b1;
      line_q <= 1'b1;
      busy_q <= 1'b0;
      stop_q <= 1'b0;
      tcnt_q <= '0;
      scnt_q <= '0;
      left_q <= '0;
      shr_q  <= '0;
    end else begin
      if (load_rise) hold_q <= din;
      if (load_rise)     tbmt_q <= 1'b0;
      else if (start_ev) tbmt_q <= 1'b1;

      if (start_ev) begin
        busy_q <= 1'b1;
        eoc_q  <= 1'b0;
        line_q <= 1'b0;
        tcnt_q <= '0;
        shr_q  <= body;
        left_q <= body_len;
      end else if (tick && busy_q) begin
        if (!stop_q) begin
          tcnt_q <= bit_end ? '0 : tcnt_q + 1'b1;
          if (bit_end) begin
            if (left_q != '0) begin
              line_q <= shr_q[0];
              shr_q  <= shr_q >> 1;
              left_q <= left_q - 1'b1;
            end else begin
              stop_q <= 1'b1;
              line_q <= 1'b1;
              scnt_q <= '0;
            end
          end
        end else begin
          scnt_q <= scnt_q + 1'b1;
          if (stop_end) begin
            busy_q <= 1'b0;
            stop_q <= 1'b0;
            eoc_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign line = line_q;
  assign tbmt = tbmt_q;
  assign eoc  = eoc_q;

  // R9
  tbmt_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tbmt_q) |-> $past(load_rise));
  // R10
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    eoc_q |-> line_q);
  // R10
  start_bit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(eoc_q) |-> !line_q);

endmodule

// File: rtl/strap_uart_rx.sv
`timescale 1ns/1ps
module strap_uart_rx
  import strap_uart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  frame_fmt_t          fmt,
  input  logic                sin,
  input  logic                rdav_n,
  output logic [MAX_BITS-1:0] data,
  output logic                dav,
  output logic                ovr,
  output logic                frm,
  output logic                perr
);
  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned HALF = OVS / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BODY, RX_STOP} rx_state_t;

  rx_state_t           st_q;
  logic                s1_q, s2_q, last_q;
  logic [CW-1:0]       cnt_q;
  logic [3:0]          idx_q;
  logic [MAX_BITS-1:0] buf_q, hold_q;
  logic                pbit_q, dav_q, ovr_q, frm_q, perr_q;
  logic                fall_ev, mid_start, start_reject, mid_bit, xfer, par_bad;

  assign fall_ev      = tick && (st_q == RX_IDLE) && last_q && !s2_q;
  assign mid_start    = tick && (st_q == RX_START) && (cnt_q == CW'(HALF - 1));
  assign start_reject = mid_start && s2_q;
  assign mid_bit      = tick && ((st_q == RX_BODY) || (st_q == RX_STOP)) &&
                        (cnt_q == CW'(OVS - 1));
  assign xfer         = mid_bit && (st_q == RX_STOP);
  assign par_bad      = !fmt.no_par && (pbit_q != fmt_parity(buf_q, fmt));

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      last_q <= 1'b1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      buf_q  <= '0;
      pbit_q <= 1'b0;
      hold_q <= '0;
      dav_q  <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      s1_q <= sin;
      s2_q <= s1_q;
      unique case (st_q)
        RX_IDLE: if (tick) begin
          last_q <= s2_q;
          if (fall_ev) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
        end
        RX_START: if (tick) begin
          if (mid_start) begin
            cnt_q <= '0;
            if (s2_q) begin
              st_q   <= RX_IDLE;
              last_q <= 1'b1;
            end else begin
              st_q  <= RX_BODY;
              idx_q <= '0;
              buf_q <= '0;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_BODY: if (tick) begin
          if (mid_bit) begin
            cnt_q <= '0;
            if (idx_q < fmt_width(fmt.len_code)) buf_q[idx_q[2:0]] <= s2_q;
            else                                 pbit_q <= s2_q;
            idx_q <= idx_q + 1'b1;
            if (idx_q == fmt_body_bits(fmt) - 4'd1) st_q <= RX_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (mid_bit) begin
            cnt_q  <= '0;
            st_q   <= RX_IDLE;
            last_q <= s2_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase

      if (xfer) begin
        hold_q <= buf_q;
        dav_q  <= 1'b1;
        ovr_q  <= dav_q & rdav_n;
        frm_q  <= ~s2_q;
        perr_q <= par_bad;
      end else if (!rdav_n) begin
        dav_q <= 1'b0;
      end
    end
  end

  assign data = hold_q;
  assign dav  = dav_q;
  assign ovr  = ovr_q;
  assign frm  = frm_q;
  assign perr = perr_q;

  // R7
  xfer_sets_chk: assert property (@(posedge clk) disable iff (rst)
    xfer |=> dav_q);
  // R7
  dav_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdav_n && !xfer) |=> !dav_q);
  // R3
  no_par_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && fmt.no_par) |=> !perr_q);
  // R6
  noise_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (start_reject && rdav_n) |=> $stable(dav_q));

endmodule

// File: rtl/strap_uart.sv
`timescale 1ns/1ps
module strap_uart
  import strap_uart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       ext_rst,
  input  logic       tx_tick16,
  input  logic       rx_tick16,
  input  logic       ctl_strobe,
  input  logic [1:0] ctl_len,
  input  logic       ctl_even,
  input  logic       ctl_two_stop,
  input  logic       ctl_no_par,
  input  logic [7:0] tx_data,
  input  logic       tx_load,
  output logic       tx_serial,
  output logic       tx_empty,
  output logic       tx_done,
  input  logic       rx_serial,
  input  logic       dav_clr_n,
  output logic       rx_ready,
  output logic       rx_overrun,
  output logic       rx_frame_err,
  output logic       rx_parity_err,
  input  logic       rd_data_n,
  input  logic       rd_stat_n,
  output logic [7:0] rd_bus,
  output logic       rd_bus_oe
);
  frame_fmt_t          fmt_q;
  logic [MAX_BITS-1:0] rx_char;
  logic [7:0]          stat_word;

  // control latch: follows inputs while strobe is high, untouched by ext_rst
  always_ff @(posedge clk) begin
    if (ctl_strobe) fmt_q <= '{len_code: ctl_len, even_par: ctl_even,
                               two_stop: ctl_two_stop, no_par: ctl_no_par};
  end

  strap_uart_tx #(.OVS(OVS)) u_tx (
    .clk (clk), .rst (ext_rst), .tick (tx_tick16), .fmt (fmt_q),
    .load(tx_load), .din (tx_data),
    .line(tx_serial), .tbmt(tx_empty), .eoc (tx_done)
  );

  strap_uart_rx #(.OVS(OVS)) u_rx (
    .clk (clk), .rst (ext_rst), .tick (rx_tick16), .fmt (fmt_q),
    .sin (rx_serial), .rdav_n(dav_clr_n),
    .data(rx_char), .dav (rx_ready), .ovr (rx_overrun),
    .frm (rx_frame_err), .perr(rx_parity_err)
  );

  assign stat_word = {3'b000, tx_empty, rx_ready, rx_overrun, rx_frame_err, rx_parity_err};
  assign rd_bus_oe = ~rd_data_n | ~rd_stat_n;

  always_comb begin
    if (!rd_stat_n)      rd_bus = stat_word;
    else if (!rd_data_n) rd_bus = rx_char;
    else                 rd_bus = '0;
  end

  // R11
  ext_reset_chk: assert property (@(posedge clk) disable iff (ext_rst)
    $past(ext_rst) |-> (tx_serial && tx_done && tx_empty && !rx_ready &&
                        !rx_overrun && !rx_frame_err && !rx_parity_err));

endmodule

// File: tb/strap_uart_test.sv
`timescale 1ns/1ps
module strap_uart_test;
  logic       clk = 1'b0;
  logic       ext_rst, tx_tick16, rx_tick16, ctl_strobe;
  logic [1:0] ctl_len;
  logic       ctl_even, ctl_two_stop, ctl_no_par;
  logic [7:0] tx_data;
  logic       tx_load, tx_serial, tx_empty, tx_done;
  logic       rx_serial, dav_clr_n;
  logic       rx_ready, rx_overrun, rx_frame_err, rx_parity_err;
  logic       rd_data_n, rd_stat_n;
  logic [7:0] rd_bus;
  logic       rd_bus_oe;

  always #4 clk = ~clk;

  strap_uart uut (
    .clk(clk), .ext_rst(ext_rst), .tx_tick16(tx_tick16), .rx_tick16(rx_tick16),
    .ctl_strobe(ctl_strobe), .ctl_len(ctl_len), .ctl_even(ctl_even),
    .ctl_two_stop(ctl_two_stop), .ctl_no_par(ctl_no_par),
    .tx_data(tx_data), .tx_load(tx_load), .tx_serial(tx_serial),
    .tx_empty(tx_empty), .tx_done(tx_done), .rx_serial(rx_serial),
    .dav_clr_n(dav_clr_n), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .rd_data_n(rd_data_n), .rd_stat_n(rd_stat_n), .rd_bus(rd_bus), .rd_bus_oe(rd_bus_oe)
  );

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  int dav_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic bit exp_par(input logic [7:0] d, input int n, input bit even);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    return even ? bit'(ones % 2) : bit'(1 - ones % 2);
  endfunction

  function automatic int stop_ticks(input int len, input bit two);
    if (!two) return 16;
    return (len == 0) ? 24 : 32;
  endfunction

  function automatic logic [7:0] mask_of(input int n);
    return 8'((1 << n) - 1);
  endfunction

  task automatic set_fmt(input int len, input int pm, input bit two);
    @(negedge clk);
    ctl_len = 2'(len); ctl_even = (pm == 1); ctl_no_par = (pm == 2); ctl_two_stop = two;
    ctl_strobe = 1'b1;
    @(negedge clk);
    ctl_strobe = 1'b0;
  endtask

  task automatic read_bus(input bit dn, input bit sn, output logic [7:0] v, output logic oe);
    rd_data_n = dn; rd_stat_n = sn;
    #1;
    v = rd_bus; oe = rd_bus_oe;
    rd_data_n = 1'b1; rd_stat_n = 1'b1;
  endtask

  // sends one character and decodes the line at mid-bit
  task automatic tx_check(input logic [7:0] d, input int len, input int pm, input bit two);
    int n, pb, k;
    int unsigned t0;
    n  = len + 5;
    pb = (pm == 2) ? 0 : 1;
    @(negedge clk);
    tx_data = d; tx_load = 1'b1;
    @(negedge clk);
    chk(tx_empty == 1'b0, "R9 load clears empty", int'(tx_empty), 0);
    tx_load = 1'b0;
    k = 0;
    while (tx_serial !== 1'b0 && k < 100) begin @(negedge clk); k++; end
    t0 = cyc;
    chk(tx_empty == 1'b1, "R9 empty after move", int'(tx_empty), 1);
    chk(tx_done == 1'b0, "R10 done low at start", int'(tx_done), 0);
    repeat (8) @(negedge clk);
    chk(tx_serial == 1'b0, "R5 start bit", int'(tx_serial), 0);
    for (int i = 0; i < n; i++) begin
      repeat (16) @(negedge clk);
      chk(tx_serial == d[i], "R1 data bit", int'(tx_serial), int'(d[i]));
    end
    if (pb == 1) begin
      repeat (16) @(negedge clk);
      chk(tx_serial == exp_par(d, n, pm == 1), "R2 parity bit", int'(tx_serial),
          int'(exp_par(d, n, pm == 1)));
    end
    repeat (16) @(negedge clk);
    chk(tx_serial == 1'b1, "R3 stop follows", int'(tx_serial), 1);
    k = 0;
    while (tx_done !== 1'b1 && k < 100) begin @(negedge clk); k++; end
    chk(int'(cyc - t0) == 16 * (1 + n + pb) + stop_ticks(len, two), "R4 frame length",
        int'(cyc - t0), 16 * (1 + n + pb) + stop_ticks(len, two));
    chk(tx_serial == 1'b1, "R10 idle high", int'(tx_serial), 1);
  endtask

  task automatic drive_bit(input logic b);
    rx_serial = b;
    repeat (16) begin @(negedge clk); if (rx_ready) dav_seen++; end
  endtask

  task automatic rx_frame(input logic [7:0] d, input int len, input int pm,
                          input bit bad_par, input bit bad_stop);
    int n;
    n = len + 5;
    dav_seen = 0;
    drive_bit(1'b0);
    for (int i = 0; i < n; i++) drive_bit(d[i]);
    if (pm != 2) drive_bit(exp_par(d, n, pm == 1) ^ bad_par);
    drive_bit(~bad_stop);
    rx_serial = 1'b1;
    repeat (24) begin @(negedge clk); if (rx_ready) dav_seen++; end
  endtask

  task automatic rx_check(input logic [7:0] d, input int len, input int pm,
                          input bit bad_par, input bit bad_stop);
    logic [7:0] v, s;
    logic oe;
    bit pe;
    rx_frame(d, len, pm, bad_par, bad_stop);
    pe = bad_par && (pm != 2);
    chk(rx_ready == 1'b1, "R7 ready after frame", int'(rx_ready), 1);
    read_bus(1'b0, 1'b1, v, oe);
    chk(v == (d & mask_of(len + 5)), "R1 received char", int'(v), int'(d & mask_of(len + 5)));
    chk(oe == 1'b1, "R13 oe on data read", int'(oe), 1);
    read_bus(1'b1, 1'b0, s, oe);
    chk(s == {3'b000, 1'b1, 1'b1, 1'b0, bad_stop, pe}, "R8 R2 R3 status word", int'(s),
        int'({3'b000, 1'b1, 1'b1, 1'b0, bad_stop, pe}));
    @(negedge clk) dav_clr_n = 1'b0;
    @(negedge clk) dav_clr_n = 1'b1;
    chk(rx_ready == 1'b0, "R7 clear ready", int'(rx_ready), 0);
    chk(rx_frame_err == bad_stop, "R7 clear leaves flags", int'(rx_frame_err), int'(bad_stop));
    read_bus(1'b0, 1'b1, v, oe);
    chk(v == (d & mask_of(len + 5)), "R7 clear leaves data", int'(v), int'(d & mask_of(len + 5)));
  endtask

  initial begin
    logic [7:0] v, d;
    logic oe;
    ext_rst = 1'b1; tx_tick16 = 1'b1; rx_tick16 = 1'b1;
    ctl_strobe = 1'b1; ctl_len = 2'b11; ctl_even = 1'b0; ctl_two_stop = 1'b0; ctl_no_par = 1'b0;
    tx_data = 8'h00; tx_load = 1'b0; rx_serial = 1'b1; dav_clr_n = 1'b1;
    rd_data_n = 1'b1; rd_stat_n = 1'b1;
    repeat (4) @(negedge clk);
    ext_rst = 1'b0; ctl_strobe = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(tx_serial && tx_empty && tx_done, "R11 tx reset state",
        int'({tx_serial, tx_empty, tx_done}), 7);
    chk(!rx_ready && !rx_overrun && !rx_frame_err && !rx_parity_err, "R11 rx reset state",
        int'({rx_ready, rx_overrun, rx_frame_err, rx_parity_err}), 0);
    read_bus(1'b1, 1'b1, v, oe);
    chk(!oe && v == 8'h00, "R13 bus idle", int'({oe, v}), 0);

    // sweep of every format
    for (int len = 0; len < 4; len++)
      for (int pm = 0; pm < 3; pm++)
        for (int two = 0; two < 2; two++) begin
          set_fmt(len, pm, bit'(two));
          d = 8'h5A ^ 8'(len * 37 + pm * 11 + two * 3);
          tx_check(d, len, pm, bit'(two));
          tx_check(~d, len, pm, bit'(two));
          rx_check(d, len, pm, 1'b0, 1'b0);
          rx_check(~d, len, pm, 1'b1, 1'b0);
          rx_check(d ^ 8'h33, len, pm, 1'b0, 1'b1);
        end

    // R6 noise start
    set_fmt(3, 0, 1'b0);
    @(negedge clk) rx_serial = 1'b0;
    repeat (4) @(negedge clk);
    rx_serial = 1'b1;
    repeat (40) @(negedge clk);
    chk(rx_ready == 1'b0, "R6 short start ignored", int'(rx_ready), 0);
    rx_check(8'hC3, 3, 0, 1'b0, 1'b0);

    // R8 overrun
    rx_frame(8'h11, 3, 0, 1'b0, 1'b0);
    rx_frame(8'h22, 3, 0, 1'b0, 1'b0);
    chk(rx_overrun == 1'b1, "R8 overrun set", int'(rx_overrun), 1);
    read_bus(1'b0, 1'b1, v, oe);
    chk(v == 8'h22, "R8 newest char kept", int'(v), 8'h22);
    @(negedge clk) dav_clr_n = 1'b0;
    @(negedge clk) dav_clr_n = 1'b1;
    chk(rx_overrun == 1'b1, "R7 clear keeps overrun", int'(rx_overrun), 1);
    rx_frame(8'h44, 3, 0, 1'b0, 1'b0);
    chk(rx_overrun == 1'b0, "R8 overrun cleared", int'(rx_overrun), 0);

    // R7 transfer and clear in the same cycle
    @(negedge clk) dav_clr_n = 1'b0;
    rx_frame(8'h96, 3, 0, 1'b0, 1'b0);
    chk(dav_seen == 1, "R7 transfer wins over clear", dav_seen, 1);
    chk(rx_overrun == 1'b0, "R8 no overrun when cleared", int'(rx_overrun), 0);
    dav_clr_n = 1'b1;
    read_bus(1'b0, 1'b1, v, oe);
    chk(v == 8'h96, "R7 char after same-cycle clear", int'(v), 8'h96);

    // R13 status priority
    rx_frame(8'h0F, 3, 0, 1'b0, 1'b1);
    read_bus(1'b0, 1'b0, v, oe);
    chk(v == 8'h1A && oe, "R13 status priority", int'(v), 8'h1A);

    // R12 latch holds after inputs move
    set_fmt(0, 1, 1'b1);
    @(negedge clk);
    ctl_len = 2'b11; ctl_even = 1'b0; ctl_two_stop = 1'b0; ctl_no_par = 1'b1;
    tx_check(8'h15, 0, 1, 1'b1);

    // R11 reset mid-frame, latch kept
    rx_frame(8'h07, 0, 1, 1'b0, 1'b1);
    @(negedge clk);
    tx_data = 8'h00; tx_load = 1'b1;
    @(negedge clk) tx_load = 1'b0;
    repeat (20) @(negedge clk);
    ext_rst = 1'b1;
    @(negedge clk) ext_rst = 1'b0;
    chk(tx_serial && tx_done && tx_empty, "R11 tx forced idle",
        int'({tx_serial, tx_done, tx_empty}), 7);
    chk(!rx_ready && !rx_frame_err, "R11 rx flags cleared",
        int'({rx_ready, rx_frame_err}), 0);
    read_bus(1'b0, 1'b1, v, oe);
    chk(v == 8'h00, "R11 holding cleared", int'(v), 0);
    tx_check(8'h0A, 0, 1, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule